// File: doc/BRIEF.md
# Two-Level Memory-Decoded Mealy Controller

This block is a Mealy state machine whose output and next-state logic are split into two levels. A small combinational front end looks at the current state code and picks a few input bits. From these it forms two short codes that only mean something inside the current state. The first is a local output selector and the second is a local successor selector. Two constant lookup tables then do the wide work. The output table is addressed by the current state code joined with the local output selector, and it returns the full output word. The successor table is addressed by the current state code joined with the local successor selector, and it returns the next state code. The state register loads that code on every clock edge.

The default configuration has 10 inputs, a 9-bit output word and 33 states. States are held as 6-bit codes, and both local selectors are 4 bits wide, so each table has 1024 words. In this configuration each state reads two input bits for each selector, so only local codes 0 to 3 ever occur. Table words at addresses that are never formed are filled with zero. The table contents are computed from a fixed rule, which makes the controller's behaviour fully predictable from its inputs.

Top module: `mealy_two_level`

## Requirements
- R1: A synchronous active-high reset loads state code 0. At the first edge with reset low, the successor is computed from state 0.
- R2: In state s, the local successor selector is {x_in[s mod 10], x_in[(s+3) mod 10]}, with the first bit as the most significant. The upper two selector bits are zero.
- R3: In state s, the local output selector is {x_in[(s+5) mod 10], x_in[(s+7) mod 10]}, with the first bit as the most significant. The upper two selector bits are zero.
- R4: On each clock edge without reset, the state becomes (s + 2*k + 3) mod 33, where k is the local successor selector.
- R5: The output word is laid out as follows: bits 8:7 hold the local output selector, bits 6:1 hold the current state code, and bit 0 holds the XOR of bits 8:1.
- R6: The output follows input changes within the same cycle, without waiting for a clock edge (Mealy behaviour).
- R7: The state code shown in output bits 6:1 never exceeds 32. Stepping past 32 wraps modulo 33.
- R8: Input bits that the current state does not select have no effect on the output word or on the next state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 10 | Controller inputs |
| y_out | output | 9 | Output word read from the output table |

## Verification
The assertions assume that reset is held high at time zero and stays high for at least one edge. They also assume that the inputs are settled by each rising edge. The bench meets both conditions: it starts with reset asserted, and it changes the inputs only just after the falling edge, a few nanoseconds before sampling. The successor check depends on the register having loaded from a valid state. This holds because every path, from reset onward, passes only through the 33 valid codes. The bench reaches the top state by steering the successor selector, and it exercises the wrap from there.

// File: rtl/mealy_two_level.sv
module mealy_two_level #(
  parameter int N_IN  = 10,
  parameter int N_OUT = 9,
  parameter int S_W   = 6,
  parameter int L_W   = 4,
  parameter int N_ST  = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  x_in,
  output logic [N_OUT-1:0] y_out
);
  localparam int ADDR_W = S_W + L_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int IW     = $clog2(N_IN);

  function automatic logic [IW-1:0] pick(input logic [S_W-1:0] s, input int off);
    int t;
    t = (int'(s) + off) % N_IN;
    return IW'(t);
  endfunction

  function automatic logic [S_W-1:0] cc_word(input int a);
    int s, k, t;
    s = a >> L_W;
    k = a % (1 << L_W);
    if (s >= N_ST || k >= 4) return '0;
    t = (s + 2 * k + 3) % N_ST;
    return S_W'(t);
  endfunction

  function automatic logic [N_OUT-1:0] y_word(input int a);
    int s, k;
    logic [N_OUT-1:0] w;
    logic [S_W-1:0] sv;
    logic [1:0] kv;
    s = a >> L_W;
    k = a % (1 << L_W);
    w = '0;
    if (s >= N_ST || k >= 4) return w;
    sv = S_W'(s);
    kv = 2'(k);
    w[S_W:1] = sv;
    w[S_W+2:S_W+1] = kv;
    w[0] = ^{kv, sv};
    return w;
  endfunction

  logic [S_W-1:0]   st;
  logic [L_W-1:0]   kn, km;
  logic [S_W-1:0]   y_rom  [DEPTH];
  logic [N_OUT-1:0] y_tab  [DEPTH];
  logic [S_W-1:0]   nxt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign y_rom[g] = cc_word(g);
    assign y_tab[g] = y_word(g);
  end

  assign kn = {{(L_W-2){1'b0}}, x_in[pick(st, 0)], x_in[pick(st, 3)]};
  assign km = {{(L_W-2){1'b0}}, x_in[pick(st, 5)], x_in[pick(st, 7)]};

  assign nxt   = y_rom[{st, kn}];
  assign y_out = y_tab[{st, km}];

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= nxt;
  end

  logic [S_W-1:0] exp_next;
  always_comb begin
    int t;
    t = (int'(st) + 2 * int'(kn) + 3) % N_ST;
    exp_next = S_W'(t);
  end

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> st == '0);
  a_r4_successor: assert property (@(posedge clk) disable iff (rst)
    !rst |=> st == $past(exp_next));
  a_r7_state_range: assert property (@(posedge clk) disable iff (rst)
    int'(y_out[S_W:1]) < N_ST);
  a_r5_state_field: assert property (@(posedge clk) disable iff (rst)
    y_out[S_W:1] == st);
  a_r5_parity: assert property (@(posedge clk) disable iff (rst)
    ^y_out == 1'b0);
endmodule

// File: tb/tb_mealy_two_level.sv
module tb_mealy_two_level;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] x_in = '0;
  logic [8:0] y_out;
  int errors = 0;
  int checks = 0;
  int s = 0;
  logic [15:0] lfsr = 16'hACE1;

  mealy_two_level dut (.clk(clk), .rst(rst), .x_in(x_in), .y_out(y_out));

  always #10 clk = ~clk;

  function automatic int kn_of(int st, logic [9:0] x);
    return 2 * int'(x[st % 10]) + int'(x[(st + 3) % 10]);
  endfunction
  function automatic int km_of(int st, logic [9:0] x);
    return 2 * int'(x[(st + 5) % 10]) + int'(x[(st + 7) % 10]);
  endfunction
  function automatic int nxt_of(int st, logic [9:0] x);
    return (st + 2 * kn_of(st, x) + 3) % 33;
  endfunction
  function automatic logic [8:0] yw(int st, logic [9:0] x);
    logic [8:0] w;
    w = 9'((km_of(st, x) << 7) | (st << 1));
    w[0] = ^w[8:1];
    return w;
  endfunction

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: y_out=%b expected %b (state %0d)", req, act, exp, s);
    end
  endtask

  task automatic cycle(input logic [9:0] x, input string req);
    @(negedge clk);
    x_in = x;
    #2;
    chk(y_out, yw(s, x), req);
    @(posedge clk);
    s = nxt_of(s, x);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    x_in = 10'h3FF;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    s = 0;
    #2;
    chk(y_out, yw(0, 10'h3FF), "R1 reset state");
    @(posedge clk);
    s = nxt_of(0, 10'h3FF);
    cycle(10'h000, "R1 first successor from state 0");
  endtask

  task automatic t_walk(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[9:0], "R2 R3 R4 R5 walk");
    end
  endtask

  task automatic t_steer_wrap;
    int guard = 0;
    logic [9:0] x;
    while (s != 32 && guard < 100) begin
      int d, k;
      d = (32 - s - 3 + 66) % 33;
      k = (d == 0 || d == 2 || d == 4 || d == 6) ? d / 2 : 0;
      x = '0;
      x[s % 10] = k[1];
      x[(s + 3) % 10] = k[0];
      cycle(x, "R4 steer");
      guard++;
    end
    checks++;
    if (s != 32) begin
      errors++;
      $display("FAIL R7: steering reached state %0d expected 32", s);
    end
    x = '0;
    x[32 % 10] = 1'b1;
    x[35 % 10] = 1'b1;
    cycle(x, "R7 top state output");
    checks++;
    if (s != 8) begin
      errors++;
      $display("FAIL R7: wrap model state %0d expected 8", s);
    end
    cycle(10'h000, "R7 wrapped state 8");
  endtask

  task automatic t_mealy;
    logic [9:0] a, b;
    a = 10'h000;
    b = '0;
    b[(s + 5) % 10] = 1'b1;
    b[(s + 7) % 10] = 1'b1;
    @(negedge clk);
    x_in = a;
    #2;
    chk(y_out, yw(s, a), "R6 before change");
    x_in = b;
    #2;
    chk(y_out, yw(s, b), "R6 same-cycle output change");
    @(posedge clk);
    s = nxt_of(s, b);
    cycle(10'h000, "R6 after edge");
  endtask

  task automatic t_ignored;
    logic [9:0] base, flip, mask;
    logic [8:0] y0;
    base = 10'b1010110011;
    mask = '0;
    mask[s % 10] = 1'b1;
    mask[(s + 3) % 10] = 1'b1;
    mask[(s + 5) % 10] = 1'b1;
    mask[(s + 7) % 10] = 1'b1;
    flip = base ^ ~mask;
    @(negedge clk);
    x_in = base;
    #2;
    y0 = y_out;
    chk(y0, yw(s, base), "R8 base pattern");
    x_in = flip;
    #2;
    chk(y_out, y0, "R8 unselected inputs leave output");
    @(posedge clk);
    s = nxt_of(s, base);
    cycle(10'h000, "R8 unselected inputs leave successor");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_walk(60);
    t_mealy();
    t_ignored();
    t_steer_wrap();
    t_walk(40);
    t_ignored();
    t_reset();
    t_mealy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule